// File: doc/BRIEF.md
# Reset and Boot-Mode Sequencer

This block controls reset for a small processor core. An active-low power-on input clears everything in the block. The first reset after power-on then keeps the core held until a fixed lock interval has elapsed, which gives the clock generator time to settle. A later reset from the external active-low pin only has to stay low for a minimum number of cycles. The clock keeps running through such a reset, so there is no second lock wait. A low pulse shorter than that minimum is treated as a glitch: the block ignores it and reports a one-cycle runt indication.

While reset is active, the block asserts separate clear and mask strobes for the stack, status and interrupt subsystems. It also samples a mode strap from a pad that doubles as a general-purpose flag. When reset ends, the block reads the boot-enable strap and the bus-request input. If booting is enabled it starts a boot-load handshake, but only once no bus request is pending. When the boot load completes, or straight away if booting is off, it releases the core to fetch from the reset vector, which is zero. After reset the flag pad is an input until software sets its direction.

Top module: `boot_reset_sequencer`

## Requirements
- R1: After `por_n` rises, the reset strobes stay asserted for at least `LOCK_CYCLES` clock cycles. They drop only after the lock count has completed and the synchronised `ext_rst_n` is high.
- R2: When the synchronised `ext_rst_n` is low for `MIN_PULSE` consecutive cycles after the first release, the block re-enters reset. It leaves reset `SYNC_STAGES`+1 cycles after `ext_rst_n` rises, without a lock wait.
- R3: A synchronised low pulse of 1 to `MIN_PULSE`-1 cycles after the first release leaves every output except `runt_flag` unchanged. `runt_flag` is 1 for exactly one cycle, the first cycle in which the synchronised reset is high again.
- R4: In reset, `stk_clr` and `stat_clr` are 1. Outside reset they are 0.
- R5: `irq_mask_all` is 1 from reset until instruction fetch is enabled, including the whole boot load. It is 0 only while `fetch_en` is 1.
- R6: In reset, `mode_strap` follows the synchronised pad value one cycle later. It therefore holds the pad value present at the release edge.
- R7: Outside reset, `mode_strap` does not change, whatever the pad does.
- R8: In reset and after release, `pad_oe` and `pad_out` are 0. A one-cycle `sw_dir_we` outside reset loads `sw_dir` (1 = drive the pad) and `sw_out`, which appear on `pad_oe` and `pad_out` on the next cycle.
- R9: `boot_req` is asserted only when `boot_en` was 1 at the release edge. With `boot_en` 0, fetch begins in the cycle after release.
- R10: If `bus_req` is 1 at release, `boot_req` stays 0 until the cycle after `bus_req` is seen low. `boot_req` never rises in a cycle whose preceding edge saw `bus_req` high.
- R11: `boot_done` during a boot load ends the load: on the next edge `fetch_en` becomes 1 and `fetch_start` pulses for one cycle. `fetch_addr` is the reset vector, which is 0 by default.
- R12: `flag_in` equals `pad_in` delayed by `SYNC_STAGES` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| bus_req | input | 1 | External bus request; holds off boot start |
| boot_en | input | 1 | Boot-enable strap, read at release |
| boot_done | input | 1 | Boot loader completion strobe |
| pad_in | input | 1 | Shared strap / flag pad input |
| sw_dir_we | input | 1 | Software write strobe for the flag pad controls |
| sw_dir | input | 1 | Pad direction to load, 1 = output |
| sw_out | input | 1 | Pad output value to load |
| stk_clr | output | 1 | Stack pointer clear, high during reset |
| stat_clr | output | 1 | Status register clear, high during reset |
| irq_mask_all | output | 1 | Global interrupt mask, high until fetch starts |
| boot_req | output | 1 | Boot load request, held until boot_done |
| fetch_en | output | 1 | Core may fetch and run |
| fetch_start | output | 1 | One-cycle pulse on the first fetch-enabled cycle |
| fetch_addr | output | PC_W | Reset vector for the first fetch |
| runt_flag | output | 1 | One-cycle report of an ignored short reset pulse |
| mode_strap | output | 1 | Latched mode strap |
| flag_in | output | 1 | Synchronised pad value for software |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |

## Verification
Both inputs that come from the pads pass through `SYNC_STAGES` flops. An input change therefore shows on `flag_in` after two edges, and it moves the state one edge after that: reset exit is due on the third edge after `ext_rst_n` rises, and reset entry one edge after the fourth synchronised low cycle. Handshake inputs act on the next edge. `bus_req` falling raises `boot_req` one cycle later, `boot_done` produces `fetch_start` one cycle later, and a software write shows on the pad one cycle later. The bench drives inputs 2 ns after a falling edge. A behavioural model advances on each rising edge, and every output is compared at the falling edge. The directed checks count falling edges from the stimulus and test the exact cycle in which a result is due.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_COLD  = 3'd0,
    ST_WARM  = 3'd1,
    ST_BWAIT = 3'd2,
    ST_BOOT  = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_e;

  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic logic is_reset_state(input seq_state_e s);
    return (s == ST_COLD) || (s == ST_WARM);
  endfunction

  // Where the sequencer goes when reset ends.
  function automatic seq_state_e release_target(input logic boot_cfg,
                                                input logic bus_busy);
    seq_state_e t;
    if (!boot_cfg)     t = ST_RUN;
    else if (bus_busy) t = ST_BWAIT;
    else               t = ST_BOOT;
    return t;
  endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (STAGES <= 1) begin : g_one
    logic [W-1:0] q_r;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) q_r <= RST_VAL;
      else        q_r <= d;
    end
    assign q = q_r;
  end else begin : g_chain
    localparam int unsigned TW = STAGES * W;
    logic [TW-1:0] chain;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[TW-W-1:0], d};
    end
    assign q = chain[TW-1 -: W];
  end

endmodule

// File: rtl/rs_lock_timer.sv
module rs_lock_timer import rstseq_pkg::*; #(
  parameter int unsigned LOCK_CYCLES = 2000
) (
  input  logic clk,
  input  logic por_n,
  input  logic counting,
  output logic locked
);

  localparam int unsigned   CW    = cnt_w(LOCK_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       cnt_q <= '0;
    else if (counting && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign locked = (cnt_q == LIMIT);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> locked) else $error("lock indication dropped"); // R1

endmodule

// File: rtl/rs_pulse_qual.sv
module rs_pulse_qual import rstseq_pkg::*; #(
  parameter int unsigned MIN_PULSE = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_s,
  input  logic armed,
  output logic hit,
  output logic runt
);

  localparam int unsigned   CW     = cnt_w(MIN_PULSE);
  localparam logic [CW-1:0] LIMIT  = CW'(MIN_PULSE);
  localparam logic [CW-1:0] HIT_AT = CW'(MIN_PULSE - 1);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              low_q <= '0;
    else if (rst_s)          low_q <= '0;
    else if (low_q != LIMIT) low_q <= low_q + 1'b1;
  end

  // the MIN_PULSE-th consecutive low cycle qualifies the pulse
  assign hit  = !rst_s && (low_q == HIT_AT);
  // the pin is high again before qualification: a glitch
  assign runt = armed && rst_s && (low_q != '0) && (low_q != LIMIT);

  AST_RUNT_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (!por_n)
    runt |-> !$past(rst_s)) else $error("runt without a low cycle"); // R3
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    hit |=> !hit) else $error("qualification repeated"); // R2

endmodule

// File: rtl/rs_flag_port.sv
module rs_flag_port (
  input  logic clk,
  input  logic por_n,
  input  logic in_reset,
  input  logic pin_s,
  input  logic sw_we,
  input  logic sw_dir,
  input  logic sw_out,
  output logic pad_oe,
  output logic pad_out,
  output logic strap_q
);

  logic dir_q, out_q, strap_r;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q   <= 1'b0;
      out_q   <= 1'b0;
      strap_r <= 1'b0;
    end else if (in_reset) begin
      dir_q   <= 1'b0;
      out_q   <= 1'b0;
      strap_r <= pin_s;
    end else if (sw_we) begin
      dir_q   <= sw_dir;
      out_q   <= sw_out;
    end
  end

  assign pad_oe  = dir_q & ~in_reset;
  assign pad_out = out_q;
  assign strap_q = strap_r;

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    (!in_reset && !$past(in_reset)) |-> $stable(strap_q)) else $error("strap moved"); // R7
  AST_PAD_INPUT_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(in_reset) |-> (!pad_oe && !pad_out)) else $error("pad driven at release"); // R8

endmodule

// File: rtl/boot_reset_sequencer.sv
module boot_reset_sequencer import rstseq_pkg::*; #(
  parameter int unsigned LOCK_CYCLES = 2000,
  parameter int unsigned MIN_PULSE   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PC_W        = 14,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            ext_rst_n,
  input  logic            bus_req,
  input  logic            boot_en,
  input  logic            boot_done,
  input  logic            pad_in,
  input  logic            sw_dir_we,
  input  logic            sw_dir,
  input  logic            sw_out,
  output logic            stk_clr,
  output logic            stat_clr,
  output logic            irq_mask_all,
  output logic            boot_req,
  output logic            fetch_en,
  output logic            fetch_start,
  output logic [PC_W-1:0] fetch_addr,
  output logic            runt_flag,
  output logic            mode_strap,
  output logic            flag_in,
  output logic            pad_oe,
  output logic            pad_out
);

  seq_state_e state_q, nxt_state;
  logic [1:0] sync_q;
  logic rst_s, pin_s, lock_done, warm_hit, runt_ev, in_reset, in_cold;
  logic release_now, boot_sel_q, fetch_start_q;

  rs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk(clk), .por_n(por_n), .d({ext_rst_n, pad_in}), .q(sync_q));
  assign rst_s = sync_q[1];
  assign pin_s = sync_q[0];

  assign in_reset = is_reset_state(state_q);
  assign in_cold  = (state_q == ST_COLD);

  rs_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .por_n(por_n), .counting(in_cold), .locked(lock_done));

  rs_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .por_n(por_n), .rst_s(rst_s), .armed(!in_cold),
    .hit(warm_hit), .runt(runt_ev));

  rs_flag_port u_flag (
    .clk(clk), .por_n(por_n), .in_reset(in_reset), .pin_s(pin_s),
    .sw_we(sw_dir_we), .sw_dir(sw_dir), .sw_out(sw_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .strap_q(mode_strap));

  // leaving reset: cold needs the lock count, warm only the pin
  assign release_now = rst_s && (in_cold ? lock_done : (state_q == ST_WARM));

  always_comb begin
    nxt_state = state_q;
    case (state_q)
      ST_COLD, ST_WARM: if (release_now) nxt_state = release_target(boot_en, bus_req);
      ST_BWAIT:         if (!bus_req)    nxt_state = ST_BOOT;
      ST_BOOT:          if (boot_done)   nxt_state = ST_RUN;
      ST_RUN:           nxt_state = ST_RUN;
      default:          nxt_state = ST_COLD;
    endcase
    if (!in_reset && warm_hit) nxt_state = ST_WARM;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q       <= ST_COLD;
      boot_sel_q    <= 1'b0;
      fetch_start_q <= 1'b0;
    end else begin
      state_q       <= nxt_state;
      if (in_reset) boot_sel_q <= boot_en;
      fetch_start_q <= (nxt_state == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign stk_clr      = in_reset;
  assign stat_clr     = in_reset;
  assign irq_mask_all = (state_q != ST_RUN);
  assign boot_req     = (state_q == ST_BOOT);
  assign fetch_en     = (state_q == ST_RUN);
  assign fetch_start  = fetch_start_q;
  assign fetch_addr   = RESET_PC;
  assign runt_flag    = runt_ev;
  assign flag_in      = pin_s;

  AST_COLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (in_cold && nxt_state != ST_COLD) |-> lock_done) else $error("early cold release"); // R1
  AST_WARM_FROM_HIT: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_WARM && $past(state_q) != ST_WARM) |-> $past(warm_hit))
    else $error("warm reset without qualified pulse"); // R2
  AST_BOOT_BUS_FREE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(boot_req) |-> !$past(bus_req)) else $error("boot started under bus request"); // R10
  AST_BOOT_CFG: assert property (@(posedge clk) disable iff (!por_n)
    boot_req |-> boot_sel_q) else $error("boot without strap"); // R9
  AST_FETCH_ONE: assert property (@(posedge clk) disable iff (!por_n)
    fetch_start |=> !fetch_start) else $error("fetch start longer than one cycle"); // R11
  AST_MASK_IN_BOOT: assert property (@(posedge clk) disable iff (!por_n)
    (boot_req || stk_clr) |-> irq_mask_all) else $error("interrupts open early"); // R5

endmodule

// File: tb/sim_boot_reset_sequencer.sv
module sim_boot_reset_sequencer;
  localparam int LOCK = 2000;
  localparam int MINP = 4;
  localparam int SYNC = 2;
  localparam int PCW  = 14;

  localparam int M_COLD = 0, M_WARM = 1, M_WAITBUS = 2, M_LOAD = 3, M_RUN = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n = 1'b1, ext_rst_n = 1'b0, bus_req = 1'b0, boot_en = 1'b1;
  logic boot_done = 1'b0, pad_in = 1'b0, sw_dir_we = 1'b0, sw_dir = 1'b0, sw_out = 1'b0;
  logic stk_clr, stat_clr, irq_mask_all, boot_req, fetch_en, fetch_start;
  logic [PCW-1:0] fetch_addr;
  logic runt_flag, mode_strap, flag_in, pad_oe, pad_out;

  boot_reset_sequencer #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP), .SYNC_STAGES(SYNC),
                         .PC_W(PCW)) u0 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .bus_req(bus_req),
    .boot_en(boot_en), .boot_done(boot_done), .pad_in(pad_in),
    .sw_dir_we(sw_dir_we), .sw_dir(sw_dir), .sw_out(sw_out),
    .stk_clr(stk_clr), .stat_clr(stat_clr), .irq_mask_all(irq_mask_all),
    .boot_req(boot_req), .fetch_en(fetch_en), .fetch_start(fetch_start),
    .fetch_addr(fetch_addr), .runt_flag(runt_flag), .mode_strap(mode_strap),
    .flag_in(flag_in), .pad_oe(pad_oe), .pad_out(pad_out));

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = M_COLD, m_lock = 0, m_low = 0, m_dir = 0, m_out = 0, m_mode = 0, m_fs = 0;
  int rq[$];
  int pq[$];

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st = M_COLD; m_lock = 0; m_low = 0; m_dir = 0; m_out = 0; m_mode = 0; m_fs = 0;
      rq.delete(); pq.delete();
      for (int i = 0; i < SYNC; i++) begin rq.push_back(0); pq.push_back(0); end
    end else begin
      int rs, ps, nst;
      bit held, qual;
      rs = rq[0]; ps = pq[0];
      held = (m_st == M_COLD) || (m_st == M_WARM);
      qual = (rs == 0) && (m_low == MINP - 1);
      nst = m_st;
      if (held) begin
        if (rs == 1 && (m_st == M_WARM || m_lock >= LOCK)) begin
          if (boot_en == 1'b0) nst = M_RUN;
          else if (bus_req)    nst = M_WAITBUS;
          else                 nst = M_LOAD;
        end
      end else if (qual) nst = M_WARM;
      else if (m_st == M_WAITBUS && !bus_req) nst = M_LOAD;
      else if (m_st == M_LOAD && boot_done)   nst = M_RUN;
      m_fs = (nst == M_RUN && m_st != M_RUN) ? 1 : 0;
      if (m_st == M_COLD && m_lock < LOCK) m_lock++;
      if (rs == 1) m_low = 0; else if (m_low < MINP) m_low++;
      if (held) begin m_dir = 0; m_out = 0; m_mode = ps; end
      else if (sw_dir_we) begin m_dir = sw_dir; m_out = sw_out; end
      m_st = nst;
      rq.push_back(int'(ext_rst_n)); void'(rq.pop_front());
      pq.push_back(int'(pad_in));    void'(pq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (cmp_on && por_n) begin
      int r;
      r = (m_st == M_COLD || m_st == M_WARM) ? 1 : 0;
      check("R4 stk_clr", stk_clr, r);
      check("R4 stat_clr", stat_clr, r);
      check("R5 irq_mask_all", irq_mask_all, m_st != M_RUN);
      check("R9 boot_req", boot_req, m_st == M_LOAD);
      check("R11 fetch_en", fetch_en, m_st == M_RUN);
      check("R11 fetch_start", fetch_start, m_fs);
      check("R3 runt_flag", runt_flag, (m_st != M_COLD) && rq[0] == 1 && m_low != 0 && m_low < MINP);
      check("R8 pad_oe", pad_oe, (m_dir == 1) && r == 0);
      check("R8 pad_out", pad_out, m_out);
      check("R6 mode_strap", mode_strap, m_mode);
      check("R12 flag_in", flag_in, pq[0]);
    end
  end

  task automatic drive_step();
    @(negedge clk); #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    int seen_runt, seen_rst, seen_boot;
    #1 por_n = 1'b0; ext_rst_n = 1'b0; pad_in = 1'b1;
    ticks(3);
    check("R4 reset stk_clr", stk_clr, 1);
    check("R8 reset pad_oe", pad_oe, 0);
    check("R11 reset fetch_en", fetch_en, 0);
    check("R5 reset irq_mask_all", irq_mask_all, 1);
    #2 por_n = 1'b1; cmp_on = 1'b1;

    // cold reset: strap driven high, toggled, then high again
    n = 0;
    for (int i = 0; i < 100; i++) begin
      drive_step(); n++;
      if (i == 40) pad_in = 1'b0;
      if (i == 70) pad_in = 1'b1;
    end
    ext_rst_n = 1'b1;
    while (stk_clr && n < 5000) begin @(negedge clk); n++; end
    check("R1 lock wait cycles >= LOCK", n >= LOCK, 1);
    check("R1 released", stk_clr, 0);
    check("R6 strap latched high", mode_strap, 1);
    check("R9 boot requested", boot_req, 1);
    check("R5 mask during boot", irq_mask_all, 1);

    // pad toggles during boot: flag_in follows, strap does not
    drive_step(); pad_in = 1'b0;
    ticks(2);
    check("R12 flag_in after sync", flag_in, 0);
    check("R7 strap unchanged", mode_strap, 1);

    drive_step(); boot_done = 1'b1;
    drive_step(); boot_done = 1'b0;
    check("R11 fetch_start pulse", fetch_start, 1);
    check("R11 fetch_addr zero", fetch_addr, 0);
    check("R5 mask cleared", irq_mask_all, 0);
    ticks(1);
    check("R11 fetch_start single", fetch_start, 0);

    // software takes the pad
    check("R8 pad input before write", pad_oe, 0);
    drive_step(); sw_dir_we = 1'b1; sw_dir = 1'b1; sw_out = 1'b1;
    drive_step(); sw_dir_we = 1'b0;
    check("R8 pad_oe after write", pad_oe, 1);
    check("R8 pad_out after write", pad_out, 1);
    pad_in = 1'b1;
    ticks(3);
    check("R7 strap after pad activity", mode_strap, 1);

    // runt of MINP-1 cycles
    seen_runt = 0; seen_rst = 0;
    drive_step(); ext_rst_n = 1'b0;
    for (int i = 0; i < MINP - 1; i++) begin drive_step(); end
    ext_rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (runt_flag) seen_runt++;
      if (stk_clr) seen_rst++;
    end
    check("R3 runt reported once", seen_runt, 1);
    check("R3 no reset on runt", seen_rst, 0);
    check("R3 pad state kept", pad_oe, 1);
    check("R3 fetch kept", fetch_en, 1);

    // exactly MINP cycles: warm reset, bus busy at release
    drive_step(); ext_rst_n = 1'b0; bus_req = 1'b1; boot_en = 1'b1; pad_in = 1'b0;
    for (int i = 0; i < MINP - 1; i++) drive_step();
    ticks(4);
    check("R2 warm reset entered", stk_clr, 1);
    #2 ext_rst_n = 1'b1;
    n = 0;
    while (stk_clr && n < 50) begin @(negedge clk); n++; end
    check("R2 release latency", n, SYNC + 1);
    check("R6 strap latched low", mode_strap, 0);
    check("R8 pad input after warm reset", pad_oe, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 boot held by bus_req", boot_req, 0);
    end
    #2 bus_req = 1'b0;
    @(negedge clk);
    check("R10 boot after bus_req drops", boot_req, 1);
    drive_step(); boot_done = 1'b1;
    drive_step(); boot_done = 1'b0;
    check("R11 fetch after boot", fetch_en, 1);

    // warm reset with booting disabled
    drive_step(); ext_rst_n = 1'b0; boot_en = 1'b0; pad_in = 1'b1;
    for (int i = 0; i < 6; i++) drive_step();
    ext_rst_n = 1'b1;
    seen_boot = 0; n = 0;
    while (!fetch_en && n < 50) begin
      @(negedge clk); n++;
      if (boot_req) seen_boot++;
    end
    check("R9 no boot when disabled", seen_boot, 0);
    check("R9 fetch right after release", n, SYNC + 1);
    check("R11 fetch_start direct", fetch_start, 1);
    check("R6 strap latched high again", mode_strap, 1);
    ticks(4);
    finish_run();
  end

endmodule